// File: doc/BRIEF.md
# PMBus Target Bus Front End

This block sits between the raw two-wire bus pins and the rest of a PMBus/SMBus target. It cleans up the clock and data lines with a filter whose required stability length can be set, finds START, repeated START and STOP conditions on the filtered lines, and collects the 7-bit target address, most significant bit first, on clock rising edges. It then tells a CPU that a transaction has begun by pulsing a start interrupt. A status flag comes with the pulse and shows whether this start is the first one after a STOP.

The interrupt can be raised at the START itself, which leaves the CPU to judge every transaction on the bus. It can also be held back until seven address bits have arrived, so that traffic for other devices never reaches the CPU. This screening is applied only to the first START after a STOP. A repeated START always interrupts at once. The ninth-clock acknowledge for the address is driven through an open-drain enable. Either the block decides it from the address comparison, or it takes the decision from a CPU input.

The control state machine has six states. IDLE means the bus is free. ADDR collects address bits. RW waits out the direction bit. ACK drives the ninth bit. PASS means the transaction was accepted. IGNORE means it was rejected. The transitions are these:
- A STOP from any state goes to IDLE.
- A START from any state except IGNORE goes to ADDR.
- ADDR goes to IGNORE on the seventh rising edge when a screened address mismatches.
- ADDR goes to RW on the eighth rising edge.
- RW goes to ACK on the following falling edge.
- ACK goes to PASS on the next falling edge if the bit was acknowledged, and to IGNORE if it was not.

Top module: `pmb_target_front`

## Requirements
- R1: A filtered line takes a new raw level only after that level has been sampled on N+1 consecutive clock edges, where N is `cfg_debounce` in the range 0 to 5. Any shorter excursion leaves the filtered line unchanged.
- R2: `cfg_debounce` values 6 and 7 need the same 6 stable samples as value 5.
- R3: START is a filtered SDA fall while filtered SCL is high. STOP is a filtered SDA rise while SCL is high. A STOP releases SDA, returns the block to IDLE and marks the bus free, so the next START counts as a first START.
- R4: When `cfg_delay_start` is 0, every START raises `start_irq` one cycle after it is detected. `start_is_first` is 1 for the first START after a STOP or reset.
- R5: When `cfg_delay_start` is 1 and the START is a first START, `start_irq` is raised with `start_is_first`=1 after the seventh address bit, and only if the 7 bits, MSB first, equal `cfg_dev_addr`. It comes before the direction bit.
- R6: When `cfg_delay_start` is 1 and a first START carries another address, the transaction raises no interrupt and never drives SDA. Any repeated START is ignored until the next STOP.
- R7: A repeated START that follows an accepted address raises `start_irq` at once, with `start_is_first`=0 and no screening, in either mode.
- R8: When `cfg_hw_ack` is 1, the block drives SDA low for the ninth clock when the address matches. On a mismatch it leaves SDA released and then ignores repeated STARTs until the next STOP.
- R9: When `cfg_hw_ack` is 0, the ninth bit is an acknowledge (SDA driven low) exactly when `cpu_ack` was 1 at the SCL fall that ends the eighth bit, whatever the address. A not-acknowledge leads to IGNORE.
- R10: `start_irq` is a single-cycle pulse.
- R11: After reset `start_irq` and `sda_oe` are 0 and the bus is treated as free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock level |
| sda_in | input | 1 | Raw bus data level |
| cfg_debounce | input | 3 | Filter setting N: N+1 stable samples, capped at 6 |
| cfg_delay_start | input | 1 | 1: screen first STARTs by address before interrupting |
| cfg_hw_ack | input | 1 | 1: the block decides the address acknowledge |
| cfg_dev_addr | input | 7 | Device address to match |
| cpu_ack | input | 1 | CPU acknowledge decision used when `cfg_hw_ack` is 0 |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| start_irq | output | 1 | One-cycle start interrupt |
| start_is_first | output | 1 | With `start_irq`: 1 for a first START, 0 for a repeated START |

## Verification
Suppose a raw pin changes at clock edge k. Two synchronizer flops and the N+1 sample filter make the filtered line change at edge k+2+min(N,5). The interrupt and the SDA enable then respond one edge later, at k+3+min(N,5), so the longest delay is 8 cycles. The bench holds every bus phase for 12 cycles, longer than that worst case. A behavioural model advances on each rising edge from the same raw inputs, and `start_irq`, `sda_oe` and the start flag are compared with it on every falling edge. Scenario checks count the interrupt pulses and sample the acknowledge in the middle of the ninth clock's high phase. In each case the sample is taken after the response is due and before the next bus phase.

// File: rtl/pmbfe_pkg.sv
package pmbfe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_RW     = 3'd2,
        ST_ACK    = 3'd3,
        ST_PASS   = 3'd4,
        ST_IGNORE = 3'd5
    } fe_state_e;

    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;
    localparam int LINE_CNT = 2;

endpackage

// File: rtl/pmbfe_deglitch.sv
module pmbfe_deglitch #(
    parameter int SET_W   = 3,
    parameter int MAX_LIM = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic [SET_W-1:0] setting,
    output logic             filt
);

    localparam int RUN_W = (MAX_LIM < 1) ? 1 : $clog2(MAX_LIM + 1);

    logic             sync_a;
    logic             sync_b;
    logic [RUN_W-1:0] run;
    logic [RUN_W-1:0] lim;

    // settings above the cap behave like the cap
    always_comb begin
        if (int'(setting) > MAX_LIM)
            lim = RUN_W'(MAX_LIM);
        else
            lim = RUN_W'(setting);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
            filt   <= 1'b1;
            run    <= '0;
        end else begin
            sync_a <= raw;
            sync_b <= sync_a;
            if (sync_b == filt) begin
                run <= '0;
            end else if (run >= lim) begin
                filt <= sync_b;
                run  <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    AST_FILT_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) |-> (filt == $past(sync_b))) else $error("filter took a level not presented"); // R1

endmodule

// File: rtl/pmbfe_cond.sv
module pmbfe_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        start_det = scl_f & sda_q & ~sda_f;
        stop_det  = scl_f & ~sda_q & sda_f;
        scl_rise  = ~scl_q & scl_f;
        scl_fall  = scl_q & ~scl_f;
    end

    AST_NO_START_STOP_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det)) else $error("start and stop at once"); // R3

endmodule

// File: rtl/pmb_target_front.sv
module pmb_target_front
    import pmbfe_pkg::*;
#(
    parameter int ADDR_BITS = 7,
    parameter int DEB_W     = 3,
    parameter int DEB_MAX   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic [DEB_W-1:0]     cfg_debounce,
    input  logic                 cfg_delay_start,
    input  logic                 cfg_hw_ack,
    input  logic [ADDR_BITS-1:0] cfg_dev_addr,
    input  logic                 cpu_ack,
    output logic                 sda_oe,
    output logic                 start_irq,
    output logic                 start_is_first
);

    localparam int CNT_W = $clog2(ADDR_BITS + 2);

    logic [LINE_CNT-1:0] raw_v;
    logic [LINE_CNT-1:0] filt_v;
    logic                scl_f;
    logic                sda_f;
    logic                start_det;
    logic                stop_det;
    logic                scl_rise;
    logic                scl_fall;

    fe_state_e            state;
    fe_state_e            nxt;
    logic [CNT_W-1:0]     bit_cnt;
    logic [ADDR_BITS-1:0] shreg;
    logic                 addr_eq;
    logic                 addr_hit;
    logic                 ack_given;
    logic                 bus_free;
    logic                 screen;

    assign raw_v[LINE_SCL] = scl_in;
    assign raw_v[LINE_SDA] = sda_in;

    for (genvar g = 0; g < LINE_CNT; g++) begin : g_line
        pmbfe_deglitch #(
            .SET_W   (DEB_W),
            .MAX_LIM (DEB_MAX)
        ) i_deglitch (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw     (raw_v[g]),
            .setting (cfg_debounce),
            .filt    (filt_v[g])
        );
    end

    assign scl_f = filt_v[LINE_SCL];
    assign sda_f = filt_v[LINE_SDA];

    pmbfe_cond i_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_f),
        .sda_f     (sda_f),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    assign addr_eq = ({shreg[ADDR_BITS-2:0], sda_f} == cfg_dev_addr);

    // next-state decision
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det && state != ST_IGNORE) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        if (bit_cnt == CNT_W'(ADDR_BITS - 1) && screen && !addr_eq)
                            nxt = ST_IGNORE;
                        else if (bit_cnt == CNT_W'(ADDR_BITS))
                            nxt = ST_RW;
                    end
                end
                ST_RW:     if (scl_fall) nxt = ST_ACK;
                ST_ACK:    if (scl_fall) nxt = ack_given ? ST_PASS : ST_IGNORE;
                ST_PASS:   ;
                ST_IGNORE: ;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // outputs and address datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe         <= 1'b0;
            start_irq      <= 1'b0;
            start_is_first <= 1'b0;
            bit_cnt        <= '0;
            shreg          <= '0;
            addr_hit       <= 1'b0;
            ack_given      <= 1'b0;
            bus_free       <= 1'b1;
            screen         <= 1'b0;
        end else begin
            start_irq <= 1'b0;
            if (stop_det) begin
                sda_oe   <= 1'b0;
                bus_free <= 1'b1;
                screen   <= 1'b0;
            end else if (start_det && state != ST_IGNORE) begin
                sda_oe         <= 1'b0;
                bit_cnt        <= '0;
                shreg          <= '0;
                bus_free       <= 1'b0;
                screen         <= cfg_delay_start & bus_free;
                start_is_first <= bus_free;
                if (!(cfg_delay_start && bus_free))
                    start_irq <= 1'b1;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[ADDR_BITS-2:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == CNT_W'(ADDR_BITS - 1)) begin
                                addr_hit <= addr_eq;
                                if (screen && addr_eq) begin
                                    start_irq      <= 1'b1;
                                    start_is_first <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_RW: begin
                        if (scl_fall) begin
                            ack_given <= cfg_hw_ack ? addr_hit : cpu_ack;
                            sda_oe    <= cfg_hw_ack ? addr_hit : cpu_ack;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall)
                            sda_oe <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_irq |=> !start_irq) else $error("interrupt longer than one cycle"); // R10

    AST_DRIVE_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ACK)) else $error("SDA driven outside ninth bit"); // R8

    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!start_irq && !sda_oe)) else $error("ignored transaction active"); // R6

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && state == ST_IDLE)) else $error("stop did not release"); // R3

    AST_SCREENED_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_irq && start_is_first && cfg_delay_start) |-> (state == ST_ADDR && bit_cnt == CNT_W'(ADDR_BITS)))
        else $error("screened interrupt at wrong point"); // R5

endmodule

// File: tb/test_pmb_target_front.sv
`timescale 1ns/1ps
module test_pmb_target_front;

    localparam int HP = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic [2:0] cfg_debounce = 3'd2;
    logic       cfg_delay_start = 1'b0;
    logic       cfg_hw_ack = 1'b1;
    logic [6:0] cfg_dev_addr = 7'h5A;
    logic       cpu_ack = 1'b0;
    logic       sda_oe;
    logic       start_irq;
    logic       start_is_first;
    logic       scl_line;
    logic       sda_line;

    int    n_vec = 0;
    int    n_bad = 0;
    int    n_irq = 0;
    bit    last_first = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R11";

    assign scl_line = scl_drv;
    assign sda_line = sda_drv & ~sda_oe;

    always #4 clk = ~clk;

    pmb_target_front i_pmb_target_front (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_in          (scl_line),
        .sda_in          (sda_line),
        .cfg_debounce    (cfg_debounce),
        .cfg_delay_start (cfg_delay_start),
        .cfg_hw_ack      (cfg_hw_ack),
        .cfg_dev_addr    (cfg_dev_addr),
        .cpu_ack         (cpu_ack),
        .sda_oe          (sda_oe),
        .start_irq       (start_irq),
        .start_is_first  (start_is_first)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_s1c, m_s2c, m_s1d, m_s2d, m_fc, m_fd, m_pc, m_pd;
    int m_runc, m_rund, m_ph, m_bits, m_sh;
    bit m_free, m_screen, m_hit, m_ack, m_irq, m_first, m_oe;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1c = 1; m_s2c = 1; m_s1d = 1; m_s2d = 1;
            m_fc = 1; m_fd = 1; m_pc = 1; m_pd = 1;
            m_runc = 0; m_rund = 0; m_ph = 0; m_bits = 0; m_sh = 0;
            m_free = 1; m_screen = 0; m_hit = 0; m_ack = 0;
            m_irq = 0; m_first = 0; m_oe = 0;
        end else begin
            bit st, sp, ri, fa;
            int lim;
            st = m_fc && m_pd && !m_fd;
            sp = m_fc && !m_pd && m_fd;
            ri = !m_pc && m_fc;
            fa = m_pc && !m_fc;
            m_irq = 0;
            if (sp) begin
                m_ph = 0; m_oe = 0; m_free = 1; m_screen = 0;
            end else if (st && m_ph != 5) begin
                m_oe = 0; m_bits = 0; m_sh = 0;
                m_first = m_free;
                m_screen = cfg_delay_start && m_free;
                if (!m_screen) m_irq = 1;
                m_free = 0;
                m_ph = 1;
            end else begin
                case (m_ph)
                    1: if (ri) begin
                        m_sh = ((m_sh << 1) | int'(m_fd)) & 32'hFF;
                        m_bits++;
                        if (m_bits == 7) begin
                            m_hit = ((m_sh & 32'h7F) == int'(cfg_dev_addr));
                            if (m_screen) begin
                                if (m_hit) begin m_irq = 1; m_first = 1; end
                                else m_ph = 5;
                            end
                        end else if (m_bits == 8) begin
                            m_ph = 2;
                        end
                    end
                    2: if (fa) begin
                        m_ack = cfg_hw_ack ? m_hit : cpu_ack;
                        m_oe = m_ack;
                        m_ph = 3;
                    end
                    3: if (fa) begin
                        m_oe = 0;
                        m_ph = m_ack ? 4 : 5;
                    end
                    default: ;
                endcase
            end
            m_pc = m_fc;
            m_pd = m_fd;
            lim = (int'(cfg_debounce) > 5) ? 5 : int'(cfg_debounce);
            if (m_s2c != m_fc) begin
                if (m_runc >= lim) begin m_fc = m_s2c; m_runc = 0; end
                else m_runc++;
            end else m_runc = 0;
            if (m_s2d != m_fd) begin
                if (m_rund >= lim) begin m_fd = m_s2d; m_rund = 0; end
                else m_rund++;
            end else m_rund = 0;
            m_s2c = m_s1c; m_s1c = scl_line;
            m_s2d = m_s1d; m_s1d = sda_line;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(start_irq === m_irq, cur_req, "start_irq vs model", int'(start_irq), int'(m_irq));
            chk(sda_oe === m_oe, cur_req, "sda_oe vs model", int'(sda_oe), int'(m_oe));
            if (m_irq)
                chk(start_is_first === m_first, cur_req, "start_is_first vs model", int'(start_is_first), int'(m_first));
            if (start_irq) begin
                n_irq++;
                last_first = start_is_first;
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_cond();
        sda_drv = 1; scl_drv = 1; wt(HP);
        sda_drv = 0; wt(HP);
        scl_drv = 0; wt(HP);
    endtask

    task automatic rstart_cond();
        sda_drv = 1; wt(HP);
        scl_drv = 1; wt(HP);
        sda_drv = 0; wt(HP);
        scl_drv = 0; wt(HP);
    endtask

    task automatic stop_cond();
        sda_drv = 0; wt(HP);
        scl_drv = 1; wt(HP);
        sda_drv = 1; wt(2 * HP);
    endtask

    task automatic put_bit(input logic b);
        sda_drv = b; wt(HP);
        scl_drv = 1; wt(HP);
        scl_drv = 0; wt(HP);
    endtask

    task automatic ack_slot(output bit acked);
        sda_drv = 1; wt(HP);
        scl_drv = 1; wt(HP / 2);
        acked = !sda_line;
        wt(HP / 2);
        scl_drv = 0; wt(HP);
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rw, output bit acked);
        for (int i = 6; i >= 0; i--) put_bit(a[i]);
        put_bit(rw);
        ack_slot(acked);
    endtask

    task automatic sda_pulse(input int w);
        sda_drv = 0;
        repeat (w) @(negedge clk);
        sda_drv = 1;
        wt(30);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        bit ak;
        int base;
        wt(3);
        cur_req = "R11";
        chk(start_irq === 1'b0, "R11", "start_irq in reset", int'(start_irq), 0);
        chk(sda_oe === 1'b0, "R11", "sda_oe in reset", int'(sda_oe), 0);
        rst_n = 1;
        wt(20);
        chk(sda_oe === 1'b0 && n_irq == 0, "R11", "quiet after reset", n_irq, 0);

        // R4 + R8: immediate interrupt, hardware ack on match
        cur_req = "R4";
        base = n_irq;
        start_cond();
        chk(n_irq == base + 1, "R4", "irq at START", n_irq - base, 1);
        chk(last_first == 1'b1, "R4", "first flag after reset", int'(last_first), 1);
        cur_req = "R8";
        send_addr(7'h5A, 1'b0, ak);
        chk(ak == 1'b1, "R8", "hw ack on match", int'(ak), 1);
        stop_cond();

        // R8: mismatch, no ack, repeated START ignored
        base = n_irq;
        start_cond();
        chk(n_irq == base + 1, "R4", "irq at START unscreened", n_irq - base, 1);
        send_addr(7'h33, 1'b0, ak);
        chk(ak == 1'b0, "R8", "no ack on mismatch", int'(ak), 0);
        rstart_cond();
        chk(n_irq == base + 1, "R8", "rstart ignored after nack", n_irq - base, 1);
        send_addr(7'h5A, 1'b0, ak);
        chk(ak == 1'b0, "R8", "still ignoring until STOP", int'(ak), 0);
        stop_cond();

        // R5 + R7: delayed interrupt on match, then repeated START
        cfg_delay_start = 1;
        cur_req = "R5";
        base = n_irq;
        start_cond();
        chk(n_irq == base, "R5", "no irq at screened START", n_irq - base, 0);
        for (int i = 6; i >= 1; i--) put_bit(cfg_dev_addr[i]);
        chk(n_irq == base, "R5", "no irq before 7th bit", n_irq - base, 0);
        put_bit(cfg_dev_addr[0]);
        chk(n_irq == base + 1, "R5", "irq after 7th bit", n_irq - base, 1);
        chk(last_first == 1'b1, "R5", "first flag screened", int'(last_first), 1);
        put_bit(1'b0);
        ack_slot(ak);
        chk(ak == 1'b1, "R5", "ack after screened match", int'(ak), 1);
        cur_req = "R7";
        rstart_cond();
        chk(n_irq == base + 2, "R7", "rstart irq unscreened", n_irq - base, 2);
        chk(last_first == 1'b0, "R7", "rstart flag", int'(last_first), 0);
        send_addr(7'h5A, 1'b1, ak);
        chk(ak == 1'b1, "R7", "ack after rstart", int'(ak), 1);
        stop_cond();

        // R6: screened out
        cur_req = "R6";
        base = n_irq;
        start_cond();
        send_addr(7'h11, 1'b0, ak);
        chk(n_irq == base, "R6", "no irq for other device", n_irq - base, 0);
        chk(ak == 1'b0, "R6", "no drive for other device", int'(ak), 0);
        rstart_cond();
        send_addr(7'h5A, 1'b0, ak);
        chk(n_irq == base, "R6", "rstart screened-out ignored", n_irq - base, 0);
        chk(ak == 1'b0, "R6", "no ack after screened rstart", int'(ak), 0);
        stop_cond();
        cur_req = "R3";
        start_cond();
        send_addr(7'h5A, 1'b0, ak);
        chk(n_irq == base + 1 && last_first, "R3", "STOP frees bus", n_irq - base, 1);
        stop_cond();

        // R9: CPU-decided acknowledge
        cfg_delay_start = 0;
        cfg_hw_ack = 0;
        cur_req = "R9";
        cpu_ack = 1;
        start_cond();
        send_addr(7'h11, 1'b0, ak);
        chk(ak == 1'b1, "R9", "cpu ack on any address", int'(ak), 1);
        stop_cond();
        cpu_ack = 0;
        start_cond();
        send_addr(7'h5A, 1'b0, ak);
        chk(ak == 1'b0, "R9", "cpu nack on match", int'(ak), 0);
        rstart_cond();
        cpu_ack = 1;
        send_addr(7'h5A, 1'b0, ak);
        chk(ak == 1'b0, "R9", "nack leads to ignore", int'(ak), 0);
        stop_cond();

        // R7 in immediate mode
        cfg_hw_ack = 1;
        cur_req = "R7";
        base = n_irq;
        start_cond();
        send_addr(7'h5A, 1'b0, ak);
        rstart_cond();
        chk(n_irq == base + 2 && !last_first, "R7", "rstart immediate mode", n_irq - base, 2);
        stop_cond();

        // R1 / R2: filter length, glitches on SDA while SCL high
        for (int s = 0; s < 8; s++) begin
            int lim;
            cfg_debounce = 3'(s);
            lim = (s > 5) ? 5 : s;
            cur_req = (s > 5) ? "R2" : "R1";
            wt(20);
            base = n_irq;
            if (lim > 0) begin
                sda_pulse(lim);
                chk(n_irq == base, cur_req, "short glitch rejected", n_irq - base, 0);
            end
            sda_pulse(lim + 1);
            chk(n_irq == base + 1, cur_req, "N+1 pulse accepted", n_irq - base, 1);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++;
            n_bad++;
            $display("FAIL R10 watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule